// File: doc/BRIEF.md
# DRAM Refresh Cycle Generator

This block steals bus time from the CPU sequencer at a regular rate so that dynamic memory keeps its contents. It counts bus states (one state is one clock). When a programmed number of states has gone by since the last refresh ended, it raises a pending request. The CPU sequencer grants that request at the end of one of its machine cycles. The block then runs one refresh cycle: the 8-bit refresh row address appears on the low address byte, and the refresh and memory-request strobes are driven high. Once the cycle ends, the row address steps on by one.

A 4-bit control word sets three things: the interval between refreshes (10, 20, 40 or 80 states), whether each refresh cycle gets one extra wait state, and whether refresh runs at all.

The cycle-boundary handshake follows valid/ready rules. `ref_valid_o` is the pending request. Once it is raised it stays high until the sequencer answers with `cyc_ready_i` at a machine-cycle boundary, so the sequencer applies back-pressure simply by holding ready low. A transfer occurs on a clock edge where both are high. The only other event that drops the request is clearing the enable bit.

Top module: `rfsh_gen`

## Requirements
- R1: During every state of a refresh cycle, `addr_o` carries the refresh row address, and that value is steady for the whole cycle. Outside refresh cycles, `addr_o` is 0.
- R2: `rfsh_o` and `mreq_o` are both high in every state of a refresh cycle. Both are low at all other times.
- R3: Control bits [1:0] select the interval: 00 gives 10 states, 01 gives 20, 10 gives 40 and 11 gives 80. `ref_valid_o` rises after exactly that many states, counted from the end of the previous refresh cycle.
- R4: When control bit [2] is 0, a refresh cycle lasts 2 states. When it is 1, the cycle lasts 3 states. The value used is the one set at the moment of grant.
- R5: While control bit [3] is 0, no refresh request is raised and no refresh cycle runs. The refresh row address is kept, and refresh resumes from it once the bit is set again.
- R6: Once raised, `ref_valid_o` stays high until a clock edge on which `cyc_ready_i` is high. The refresh cycle starts on that edge, and it never starts without such an edge.
- R7: The refresh row address increments by one after each completed refresh cycle, and it wraps from 255 to 0.
- R8: After reset, the row address is 0 and all outputs are low. The control word is refresh enabled, wait state on, and the 80-state interval.
- R9: The interval count does not advance while a request is pending or a refresh is running. How long the sequencer holds off a grant therefore does not shorten the next interval.
- R10: A write on `cfg_we_i` loads `cfg_wdata_i` into the control word at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 4 | Control word: [3] enable, [2] wait state, [1:0] interval select |
| cyc_ready_i | input | 1 | Sequencer is at a machine-cycle boundary and can give up the bus |
| ref_valid_o | output | 1 | Refresh request pending |
| addr_o | output | 8 | Low address byte, carrying the row address during refresh |
| rfsh_o | output | 1 | Refresh strobe, active high |
| mreq_o | output | 1 | Memory request strobe, active high |

## Verification
The bench measures the gap between the end of each refresh and the next request rise, for every interval code used and across a grant held back by the sequencer. An off-by-one counter, a decode of the wrong interval, or a counter that runs while a request is pending would each show up as a wrong gap. Every cycle's length and address are compared against a queue of expected refreshes, which runs past 256 refreshes. A lost wait-state setting, a missing increment or a bad wrap would therefore appear as a mismatch. A disable window checks that no request or strobe leaks out and that the address resumes where it stopped, which catches a design that resets the address or keeps counting while disabled.

// File: rtl/rfsh_gen_pkg.sv
package rfsh_gen_pkg;

  typedef enum logic [1:0] {
    IVL_X1 = 2'd0,
    IVL_X2 = 2'd1,
    IVL_X4 = 2'd2,
    IVL_X8 = 2'd3
  } ivl_sel_e;

  typedef struct packed {
    logic     en;
    logic     wait_st;
    ivl_sel_e sel;
  } rfsh_cfg_t;

  localparam rfsh_cfg_t CFG_RESET = '{en: 1'b1, wait_st: 1'b1, sel: IVL_X8};

endpackage

// File: rtl/rfsh_gen_timer.sv
module rfsh_gen_timer
  import rfsh_gen_pkg::*;
#(
  parameter int BASE_STATES = 10
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en_i,
  input  ivl_sel_e sel_i,
  input  logic     busy_i,
  input  logic     grant_i,
  output logic     pend_o
);

  localparam int MAX_STATES = BASE_STATES * 8;
  localparam int CNT_W      = $clog2(MAX_STATES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             pend_q;

  always_comb last_cnt = (CNT_W'(BASE_STATES) << sel_i) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (grant_i) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (busy_i || pend_q) begin
      cnt_q  <= '0;
    end else if (cnt_q >= last_cnt) begin
      cnt_q  <= '0;
      pend_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign pend_o = pend_q;

  // R9
  pend_not_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> !pend_o);

  // R5
  pend_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !pend_o);

endmodule

// File: rtl/rfsh_gen_cycle.sv
module rfsh_gen_cycle #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_i,
  input  logic              wait_i,
  output logic              active_o,
  output logic [ADDR_W-1:0] row_o
);

  logic [1:0]        st_q;
  logic              active_q;
  logic              wait_q;
  logic [ADDR_W-1:0] row_q;
  logic [1:0]        last_st;

  always_comb last_st = wait_q ? 2'd2 : 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= '0;
      active_q <= 1'b0;
      wait_q   <= 1'b0;
      row_q    <= '0;
    end else if (grant_i) begin
      st_q     <= '0;
      active_q <= 1'b1;
      wait_q   <= wait_i;
    end else if (active_q) begin
      if (st_q == last_st) begin
        active_q <= 1'b0;
        row_q    <= row_q + ADDR_W'(1);
      end else begin
        st_q <= st_q + 2'd1;
      end
    end
  end

  assign active_o = active_q;
  assign row_o    = row_q;

  // R7
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> row_q == $past(row_q) + ADDR_W'(1));

  // R4
  three_state_needs_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q) && $past(active_q, 2)) |-> wait_q);

  // R4
  never_four_states_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q) && $past(active_q, 2)) |=> !active_q);

endmodule

// File: rtl/rfsh_gen.sv
module rfsh_gen
  import rfsh_gen_pkg::*;
#(
  parameter int BASE_STATES = 10,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_wdata_i,
  input  logic              cyc_ready_i,
  output logic              ref_valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rfsh_o,
  output logic              mreq_o
);

  rfsh_cfg_t         cfg_q;
  logic              pend;
  logic              active;
  logic              grant;
  logic [ADDR_W-1:0] row;

  always_ff @(posedge clk) begin
    if (!rst_n)        cfg_q <= CFG_RESET;
    else if (cfg_we_i) cfg_q <= rfsh_cfg_t'(cfg_wdata_i);
  end

  assign grant = pend && cyc_ready_i && cfg_q.en;

  rfsh_gen_timer #(.BASE_STATES(BASE_STATES)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (cfg_q.en),
    .sel_i   (cfg_q.sel),
    .busy_i  (active),
    .grant_i (grant),
    .pend_o  (pend)
  );

  rfsh_gen_cycle #(.ADDR_W(ADDR_W)) cycle_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant_i  (grant),
    .wait_i   (cfg_q.wait_st),
    .active_o (active),
    .row_o    (row)
  );

  assign ref_valid_o = pend;
  assign addr_o      = active ? row : '0;
  assign rfsh_o      = active;
  assign mreq_o      = active;

  // R6
  start_needs_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfsh_o) |-> $past(ref_valid_o && cyc_ready_i));

  // R6
  request_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid_o && !cyc_ready_i && !cfg_we_i) |=> ref_valid_o);

  // R1
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_o && $past(rfsh_o)) |-> $stable(addr_o));

  // R5
  no_start_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.en && !rfsh_o) |=> !rfsh_o);

endmodule

// File: tb/rfsh_gen_tb_top.sv
module rfsh_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_wdata = 4'd0;
  logic       cyc_ready = 1'b1;
  logic       ref_valid;
  logic [7:0] addr;
  logic       rfsh;
  logic       mreq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int exp_addr_q[$];
  int exp_len_q[$];
  int next_addr = 0;
  int exp_gap = 80;
  bit gap_hold = 0;

  int  run_len = 0;
  int  cur_addr = 0;
  bit  in_ref = 0;
  bit  have_fall = 0;
  int  since_fall = 0;

  always #10 clk = ~clk;

  rfsh_gen dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we_i    (cfg_we),
    .cfg_wdata_i (cfg_wdata),
    .cyc_ready_i (cyc_ready),
    .ref_valid_o (ref_valid),
    .addr_o      (addr),
    .rfsh_o      (rfsh),
    .mreq_o      (mreq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_ref(input int n, input int len);
    for (int i = 0; i < n; i++) begin
      exp_addr_q.push_back(next_addr);
      exp_len_q.push_back(len);
      next_addr = (next_addr + 1) % 256;
    end
  endtask

  task automatic drain();
    while (exp_addr_q.size() != 0) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [3:0] v, input int gap);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    exp_gap = gap;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Monitor: pops expected refreshes, checks strobes, address, length, gap
  always @(negedge clk) begin
    if (rst_n) begin
      if (gap_hold) have_fall = 0;
      if (rfsh) begin
        if (!in_ref) begin
          in_ref = 1;
          run_len = 1;
          cur_addr = addr;
        end else begin
          run_len++;
        end
        chk(mreq == 1'b1, "R2 mreq with rfsh", mreq, 1);
        chk(addr == cur_addr[7:0], "R1 address steady", addr, cur_addr);
      end else begin
        chk(mreq == 1'b0 && addr == 8'd0, "R1/R2 idle outputs", {23'd0, mreq, addr}, 0);
        if (in_ref) begin
          in_ref = 0;
          if (exp_addr_q.size() == 0) begin
            chk(1'b0, "R5 unexpected refresh", cur_addr, -1);
          end else begin
            chk(cur_addr == exp_addr_q[0], "R7 refresh address", cur_addr, exp_addr_q[0]);
            chk(run_len == exp_len_q[0], "R4 refresh length", run_len, exp_len_q[0]);
            void'(exp_addr_q.pop_front());
            void'(exp_len_q.pop_front());
          end
          have_fall = !gap_hold;
          since_fall = 0;
        end
        if (have_fall) begin
          if (ref_valid) begin
            chk(since_fall == exp_gap, "R3/R9 interval gap", since_fall, exp_gap);
            have_fall = 0;
          end else begin
            since_fall++;
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(rfsh == 0 && mreq == 0 && addr == 0 && ref_valid == 0, "R8 reset outputs",
        {22'd0, rfsh, mreq, ref_valid, addr}, 0);

    // R8 defaults: wait state on, 80-state gap
    push_ref(2, 3);
    drain();

    // R3 R4 R7 R10: 10 states, no wait, run past the wrap
    write_cfg(4'b1000, 10);
    push_ref(260, 2);
    drain();
    chk(next_addr == 6, "R7 wrap bookkeeping", next_addr, 6);

    // R3 R4: 20 states with wait
    write_cfg(4'b1101, 20);
    push_ref(3, 3);
    drain();

    // R6 R9: back-pressure from the sequencer
    cyc_ready = 1'b0;
    push_ref(1, 3);
    while (!ref_valid) @(negedge clk);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      chk(ref_valid == 1 && rfsh == 0, "R6 request held", {30'd0, ref_valid, rfsh}, 2);
    end
    cyc_ready = 1'b1;
    @(negedge clk);
    chk(rfsh == 1, "R6 start after ready", rfsh, 1);
    drain();
    push_ref(2, 3);
    drain();

    // R5: disable, nothing happens, address kept
    gap_hold = 1;
    write_cfg(4'b0000, 40);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      chk(ref_valid == 0 && rfsh == 0, "R5 disabled quiet", {30'd0, ref_valid, rfsh}, 0);
    end
    write_cfg(4'b1010, 40);
    gap_hold = 0;
    push_ref(3, 2);
    drain();

    // R3: 40 states with wait, 80 states no wait
    write_cfg(4'b1110, 40);
    push_ref(2, 3);
    drain();
    write_cfg(4'b1011, 80);
    push_ref(2, 2);
    drain();

    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule